// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs read and write cycles on a processor-style bus where the address and the data share the same wires. An internal requester presents an address, a direction, an upper-lane flag and write data. The sequencer then steps through a fixed cycle of four clock states. In the first state it places the address on the shared bus and pulses the address latch enable, so that external latches can hold the address. In the middle states it drives the read or write strobe. In the last state it returns every bus control to inactive. When the bus is slow, the external READY line holds the cycle open with wait states. READY passes through a two-flop synchronizer before the sequencer looks at it.

The states are `ST_IDLE`, `ST_T1`, `ST_T2`, `ST_T3`, `ST_TW` (wait) and `ST_T4`. The transitions are as follows:
- `ST_IDLE` goes to `ST_T1` on a request, and otherwise stays in `ST_IDLE`.
- `ST_T1` always goes to `ST_T2`, and `ST_T2` always goes to `ST_T3`.
- `ST_T3` goes to `ST_T4` when the synchronized READY is high, and to `ST_TW` when it is low.
- `ST_TW` stays in `ST_TW` while the synchronized READY is low, and goes back to `ST_T3` once it is high.
- `ST_T4` goes straight to `ST_T1` on a new request, and otherwise to `ST_IDLE`.

For a read, the data on the bus is taken at the end of the last `ST_T3`. It is returned with a one-cycle done pulse during `ST_T4`.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, and whenever idle, `bus_ale`, `bus_hbe`, `bus_rd`, `bus_wr`, `bus_ad_oe`, `bus_dt_tx` and `rsp_valid` are low and `req_ready` is high.
- R2: With the synchronized READY high, an accepted request passes through T1, T2, T3 and T4 on successive clocks. `rsp_valid` goes high on the third clock edge after the accepting edge.
- R3: `bus_ale` is high only in T1. In T1 the sequencer drives `req_addr` on `bus_ad_out`, with `bus_ad_oe` = 1 and `bus_dt_tx` = 1. `bus_hbe` equals `req_hi` in T1 and is low in every other state.
- R4: From T2 through the last T3 or wait state, `bus_rd` is high for a read (`req_write` = 0) and `bus_wr` is high for a write (`req_write` = 1). Both strobes are low in T1 and T4, and they are never high together.
- R5: For a write, `bus_ad_oe` = 1 and `bus_dt_tx` = 1 from T2 until T4, and `bus_ad_out` carries `req_wdata` zero-extended to the address width. For a read, `bus_ad_oe` = 0 and `bus_dt_tx` = 0 from T2 through T4.
- R6: READY passes through two flops. A T3 that sees the synchronized READY low becomes a wait state, and the sequencer stays in the wait state until the synchronized READY is high. It then runs T3 and T4, so that `rsp_valid` rises on the fourth clock edge after the raw `bus_ready` goes high during a wait.
- R7: Read data is taken from `bus_ad_in` only at the end of a T3 that sees the synchronized READY high. It is presented on `rsp_rdata` while `rsp_valid` is high.
- R8: `rsp_valid` is a one-cycle pulse in T4. In T4, `bus_ale`, `bus_hbe`, `bus_rd`, `bus_wr`, `bus_ad_oe` and `bus_dt_tx` are all low.
- R9: A request is accepted only in idle or T4, and `req_ready` is low in every other state. A request presented during T4 starts T1 on the next clock, with no idle state in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi | input | 1 | Access uses the upper byte lane |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| rsp_valid | output | 1 | Cycle done pulse (T4) |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |
| bus_ready | input | 1 | Asynchronous READY from the bus |
| bus_ad_in | input | DATA_W | Data read from the shared bus |
| bus_ad_out | output | ADDR_W | Value driven onto the shared bus |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ale | output | 1 | Address latch enable |
| bus_hbe | output | 1 | Upper byte lane enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_dt_tx | output | 1 | Data direction, 1 = outward |

## Verification
The bus outputs are decoded from the state, so each one follows the state that was entered on the previous edge. T1 appears one edge after acceptance, and with no waits the done pulse follows three edges after acceptance. When READY is raised during a wait, the done pulse is due four edges later: two edges for the synchronizer, one for the return to T3 and one for T4. The bench builds the expected state list for each cycle from its wait count. It compares every output at the falling edge after each state change. It raises READY at a chosen point in the list and changes the read data at that same moment, so that a sample taken too early is caught.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } mbs_state_e;
endpackage

// File: rtl/mbs_ready_sync.sv
module mbs_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_async,
    output logic rdy_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= rdy_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], rdy_async};
            end
        end
    endgenerate

    assign rdy_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rdy_s,
    output mbs_state_e state,
    output logic       accept,
    output logic       capture
);
    mbs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_T1 : ST_IDLE;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = rdy_s ? ST_T4 : ST_TW;
            ST_TW:   state_d = rdy_s ? ST_T3 : ST_TW;
            ST_T4:   state_d = start ? ST_T1 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign state   = state_q;
    assign accept  = start && (state_q == ST_IDLE || state_q == ST_T4);
    assign capture = (state_q == ST_T3) && rdy_s;
endmodule

// File: rtl/mbs_req_reg.sv
module mbs_req_reg #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              in_write,
    input  logic              in_hi,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] bus_data,
    output logic              cur_write,
    output logic              cur_hi,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_hi    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_write <= in_write;
            cur_hi    <= in_hi;
            cur_addr  <= in_addr;
            cur_wdata <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= bus_data;
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_hi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [ADDR_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic              bus_ale,
    output logic              bus_hbe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_dt_tx
);
    localparam int PAD_W = ADDR_W - DATA_W;

    mbs_state_e        state;
    logic              rdy_s, accept, capture;
    logic              cur_write, cur_hi;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    mbs_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rdy_async(bus_ready), .rdy_sync(rdy_s)
    );

    mbs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(req_valid), .rdy_s(rdy_s),
        .state(state), .accept(accept), .capture(capture)
    );

    mbs_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .in_write(req_write), .in_hi(req_hi), .in_addr(req_addr),
        .in_wdata(req_wdata), .bus_data(bus_ad_in),
        .cur_write(cur_write), .cur_hi(cur_hi), .cur_addr(cur_addr),
        .cur_wdata(cur_wdata), .rd_data(rsp_rdata)
    );

    always_comb begin
        bus_ad_out = '0;
        bus_ad_oe  = 1'b0;
        bus_ale    = 1'b0;
        bus_hbe    = 1'b0;
        bus_rd     = 1'b0;
        bus_wr     = 1'b0;
        bus_dt_tx  = 1'b0;
        rsp_valid  = 1'b0;
        req_ready  = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_T1: begin
                bus_ale    = 1'b1;
                bus_hbe    = cur_hi;
                bus_ad_out = cur_addr;
                bus_ad_oe  = 1'b1;
                bus_dt_tx  = 1'b1;
            end
            ST_T2, ST_T3, ST_TW: begin
                bus_rd = !cur_write;
                bus_wr = cur_write;
                if (cur_write) begin
                    bus_ad_out = {{PAD_W{1'b0}}, cur_wdata};
                    bus_ad_oe  = 1'b1;
                    bus_dt_tx  = 1'b1;
                end
            end
            ST_T4: begin
                rsp_valid = 1'b1;
                req_ready = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] bus_ad_out,
    input logic              bus_ad_oe,
    input logic              bus_ale,
    input logic              bus_hbe,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_dt_tx
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale); // R3
    AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (bus_rd || bus_wr)); // R4
    AST_HBE_IN_T1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hbe |-> bus_ale); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R4
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (!bus_ad_oe && !bus_dt_tx)); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(bus_ale || bus_hbe || bus_rd || bus_wr || bus_ad_oe || bus_dt_tx)); // R8
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_rd || bus_wr)); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale || bus_rd || bus_wr) |-> !req_ready); // R9
endmodule

bind mux_bus_seq mbs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale),
    .bus_hbe(bus_hbe), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dt_tx(bus_dt_tx)
);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int P_T1 = 1, P_T2 = 2, P_T3 = 3, P_TW = 4, P_T4 = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_hi = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          bus_ready = 1'b1;
    logic [DW-1:0] bus_ad_in = '0;
    logic [AW-1:0] bus_ad_out;
    logic          bus_ad_oe, bus_ale, bus_hbe, bus_rd, bus_wr, bus_dt_tx;

    int errors = 0;
    int checks = 0;

    logic          nx_wr, nx_hi;
    logic [AW-1:0] nx_addr;
    logic [DW-1:0] nx_wd, nx_rd;
    int            nx_k;

    always #10 clk = ~clk;

    mux_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_hi(req_hi), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_ready(bus_ready), .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale), .bus_hbe(bus_hbe),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dt_tx(bus_dt_tx)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int phase_at(input int i, input int k);
        if (i == 0) return P_T1;
        if (i == 1) return P_T2;
        if (i == 2) return P_T3;
        if (k == 0) return P_T4;
        if (i <= k + 2) return P_TW;
        if (i == k + 3) return P_T3;
        return P_T4;
    endfunction

    task automatic present(input logic wr, input logic hi, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rd, input int k);
        req_write = wr; req_hi = hi; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        bus_ready = (k == 0);
        bus_ad_in = (k == 0) ? rd : ~rd;
    endtask

    task automatic txn(input logic wr, input logic hi, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [DW-1:0] rd, input int k,
                       input bit pre, input bit follow);
        int n;
        n = (k == 0) ? 4 : k + 5;
        if (!pre) begin
            @(negedge clk);
            chk(req_ready, 1, "R9 idle ready");
            present(wr, hi, a, wd, rd, k);
        end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (pre) chk(bus_ale, 1, "R9 T4 to T1 direct");
        for (int i = 0; i < n; i++) begin
            int  ph;
            bit  mid;
            ph  = phase_at(i, k);
            mid = (ph == P_T2 || ph == P_T3 || ph == P_TW);
            chk(bus_ale, ph == P_T1, "R3 ale");
            chk(bus_hbe, (ph == P_T1) && hi, "R3 hbe");
            if (ph == P_T1) chk(bus_ad_out, a, "R3 address");
            chk(bus_rd, mid && !wr, "R4 read strobe");
            chk(bus_wr, mid && wr, "R4 write strobe");
            chk(bus_ad_oe, (ph == P_T1) || (mid && wr), "R5 drive enable");
            chk(bus_dt_tx, (ph == P_T1) || (mid && wr), "R5 direction");
            if (mid && wr) chk(bus_ad_out, {{(AW-DW){1'b0}}, wd}, "R5 write data");
            chk(rsp_valid, ph == P_T4, (k == 0) ? "R2 done timing" : "R6 done after wait");
            chk(req_ready, ph == P_T4, "R9 ready only idle/T4");
            if (ph == P_T4) begin
                chk({bus_ale, bus_hbe, bus_rd, bus_wr, bus_ad_oe, bus_dt_tx}, 0, "R8 T4 inactive");
                if (!wr) chk(rsp_rdata, rd, "R7 read data");
            end
            if (k > 0 && i == k) begin
                bus_ready = 1'b1;
                bus_ad_in = rd;
            end
            if (i == n - 1 && follow) present(nx_wr, nx_hi, nx_addr, nx_wd, nx_rd, nx_k);
            if (i < n - 1) begin
                @(posedge clk); @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({bus_ale, bus_hbe, bus_rd, bus_wr, bus_ad_oe, bus_dt_tx, rsp_valid}, 0, "R1 reset outputs");
        chk(req_ready, 1, "R1 reset ready");
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_ale, bus_rd, bus_wr, rsp_valid}, 0, "R1 idle outputs");

        txn(1'b0, 1'b0, 20'hA1234, 16'h0000, 16'hBEEF, 0, 1'b0, 1'b0); // R2 plain read
        txn(1'b1, 1'b1, 20'h0FFFF, 16'hC3A5, 16'h0000, 0, 1'b0, 1'b0); // R2 plain write, upper lane
        txn(1'b0, 1'b1, 20'h55555, 16'h0000, 16'h1357, 1, 1'b0, 1'b0); // R6 shortest wait
        txn(1'b1, 1'b0, 20'hFFFFF, 16'hFFFF, 16'h0000, 3, 1'b0, 1'b0); // R6 longer wait
        txn(1'b0, 1'b0, 20'h00001, 16'h0000, 16'h8001, 6, 1'b0, 1'b0); // R7 data only at final T3

        // R9: back-to-back from T4
        nx_wr = 1'b0; nx_hi = 1'b1; nx_addr = 20'h3C3C3; nx_wd = '0; nx_rd = 16'h2468; nx_k = 2;
        txn(1'b1, 1'b0, 20'h12345, 16'hABCD, 16'h0000, 0, 1'b0, 1'b1);
        txn(nx_wr, nx_hi, nx_addr, nx_wd, nx_rd, nx_k, 1'b1, 1'b0);

        for (int t = 0; t < 40; t++) begin
            logic          wr, hi;
            logic [AW-1:0] a;
            logic [DW-1:0] wd, rd;
            int            k;
            wr = $urandom_range(0, 1);
            hi = $urandom_range(0, 1);
            a  = AW'($urandom);
            wd = DW'($urandom);
            rd = DW'($urandom);
            k  = $urandom_range(0, 6);
            txn(wr, hi, a, wd, rd, k, 1'b0, 1'b0);
        end

        @(negedge clk);
        chk({bus_ale, bus_rd, bus_wr, bus_ad_oe, rsp_valid}, 0, "R1 idle after traffic");
        chk(req_ready, 1, "R1 ready after traffic");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule